// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Synchronizer

This block gathers up to 32 interrupt levels from peripheral modules that share only eight interrupt wires. It drives a 2-bit group code to every module; a module that sees a code drives its eight levels for that group onto the shared wires during the following clock. The block samples the wires one clock after each code, knows from a delayed copy of the code which group it has received, and writes that byte into a 32-bit pending vector presented to the core side.

A 2-bit mode input sets how many groups are scanned: one, two, three or four. The code then steps 0, 1, ... up to the last enabled group and starts again at 0. A full scan takes one to four clocks. Slices of the pending vector that belong to groups outside the active scan read as zero. Mode changes are taken only when the code wraps, so a scan in progress always finishes. Several modules may drive one level; the wire then carries the OR of all of them, and the block reports the OR.

Top module: `irq_level_sync`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `grp_sel_o` = 0 and `pending_o` = 0.
- R2: While the code has not reached the last enabled group, `grp_sel_o` increases by one on every clock.
- R3: With `mode_i` = m (scan of m+1 groups), the code that follows value m is 0, so the code repeats every m+1 clocks.
- R4: The byte on `irq_lines_i` in cycle k is written to `pending_o[8g+7:8g]`, where g is the code shown in cycle k-1. It is visible in cycle k+1.
- R5: A pending slice whose group number is above the active scan length reads as zero from the cycle after that scan length takes effect.
- R6: Each slice is replaced, not ORed, when sampled: a level clears within one scan plus two clocks after every source of it deasserts.
- R7: The active scan length is loaded from `mode_i` only at reset and at the wrap of the code. A change in the middle of a scan does not alter the code sequence until the wrap.
- R8: Wire values present during reset, and in the first cycle after it, never reach `pending_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Scan length minus one (0: 8 levels, 3: 32 levels) |
| irq_lines_i | input | 8 | Shared interrupt wires, driven by modules for the announced group |
| grp_sel_o | output | 2 | Group code broadcast to all modules |
| pending_o | output | 32 | Latched interrupt levels, group g in bits 8g+7..8g |

## Verification
The hardest case to reach from the ports is a mode write that lands in the middle of a scan. It must be deferred to the wrap, and the capture of the last old-length group must not leave stale bits once the scan shrinks. The stimulus waits until the code reads 1, lowers the mode to one group, and checks that codes 2 and 3 still follow. It then enables every source and checks that only the low byte stays set. Noise driven on the wires during reset and in the first cycle after it tests that the discarded capture never shows up in the pending vector.

// File: rtl/ils_pkg.sv
package ils_pkg;
  parameter int ILS_LINES  = 8;
  parameter int ILS_GROUPS = 4;

  // clamp a requested scan length to the number of groups built
  function automatic int unsigned clamp_last(input int unsigned req, input int unsigned groups);
    return (req > groups - 1) ? groups - 1 : req;
  endfunction
endpackage

// File: rtl/ils_seq.sv
module ils_seq #(
  parameter int GROUPS = 4,
  parameter int SELW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] mode_i,
  output logic [SELW-1:0] sel_o,
  output logic [SELW-1:0] act_o,
  output logic [SELW-1:0] cap_code_o,
  output logic            cap_vld_o
);
  import ils_pkg::*;

  logic [SELW-1:0] mode_lim;

  always_comb begin
    mode_lim = SELW'(clamp_last(int'(mode_i), GROUPS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o      <= '0;
      act_o      <= mode_lim;
      cap_code_o <= '0;
      cap_vld_o  <= 1'b0;
    end else begin
      cap_code_o <= sel_o;
      cap_vld_o  <= 1'b1;
      if (sel_o == act_o) begin
        sel_o <= '0;
        act_o <= mode_lim;
      end else begin
        sel_o <= sel_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ils_slice.sv
module ils_slice #(
  parameter int LINES = 8,
  parameter int SELW  = 2,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SELW-1:0]  act_i,
  input  logic [SELW-1:0]  cap_code_i,
  input  logic             cap_vld_i,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] q_o
);
  localparam logic [SELW-1:0] MY_CODE = SELW'(IDX);

  always_ff @(posedge clk) begin
    if (rst || (act_i < MY_CODE)) begin
      q_o <= '0;
    end else if (cap_vld_i && (cap_code_i == MY_CODE)) begin
      q_o <= lines_i;
    end
  end
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int LINES  = ils_pkg::ILS_LINES,
  parameter int GROUPS = ils_pkg::ILS_GROUPS,
  localparam int SELW  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int PW    = LINES * GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SELW-1:0]  mode_i,
  input  logic [LINES-1:0] irq_lines_i,
  output logic [SELW-1:0]  grp_sel_o,
  output logic [PW-1:0]    pending_o
);
  logic [SELW-1:0] act_mode;
  logic [SELW-1:0] cap_code;
  logic            cap_vld;

  ils_seq #(.GROUPS(GROUPS), .SELW(SELW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .sel_o      (grp_sel_o),
    .act_o      (act_mode),
    .cap_code_o (cap_code),
    .cap_vld_o  (cap_vld)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    ils_slice #(.LINES(LINES), .SELW(SELW), .IDX(g)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .act_i      (act_mode),
      .cap_code_i (cap_code),
      .cap_vld_i  (cap_vld),
      .lines_i    (irq_lines_i),
      .q_o        (pending_o[g*LINES +: LINES])
    );
  end
endmodule

// File: rtl/irq_level_sync_chk.sv
module irq_level_sync_chk #(
  parameter int LINES  = 8,
  parameter int GROUPS = 4,
  localparam int SELW  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int PW    = LINES * GROUPS
) (
  input logic             clk,
  input logic             rst,
  input logic [SELW-1:0]  sel,
  input logic [SELW-1:0]  act,
  input logic [LINES-1:0] lines,
  input logic [PW-1:0]    pending
);
  function automatic logic [PW-1:0] live_mask(input logic [SELW-1:0] a);
    logic [PW-1:0] m;
    m = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (g <= int'(a)) m[g*LINES +: LINES] = '1;
    end
    return m;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sel == '0 && pending == '0)); // R1
  AST_CODE_STEPS: assert property (@(posedge clk) disable iff (rst) (sel != act) |=> (sel == $past(sel) + 1'b1)); // R2
  AST_CODE_WRAPS: assert property (@(posedge clk) disable iff (rst) (sel == act) |=> (sel == '0)); // R3
  AST_GROUP_LANDS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(sel) <= act) |=> (pending[$past(sel, 2)*LINES +: LINES] == $past(lines))); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((pending & ~live_mask($past(act))) == '0)); // R5
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst) (sel != act) |=> $stable(act)); // R7
endmodule

bind irq_level_sync irq_level_sync_chk #(.LINES(LINES), .GROUPS(GROUPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel     (grp_sel_o),
  .act     (act_mode),
  .lines   (irq_lines_i),
  .pending (pending_o)
);

// File: tb/tb_irq_level_sync.sv
module tb_irq_level_sync;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd3;
  logic [7:0]  lines = 8'h00;
  logic [1:0]  sel;
  logic [31:0] pend;

  logic [31:0] src_a = '0, src_b = '0;
  bit          noise = 1'b0;
  bit          chk_en = 1'b0;
  int          vectors = 0, errors = 0;

  // reference model state
  int          m_sel = 0, m_act = 3, m_prev = 0, seen_prev = 0;
  bit          m_vld = 0;
  logic [31:0] m_pend = '0;

  always #5 clk = ~clk;

  irq_level_sync dut (
    .clk(clk), .rst(rst), .mode_i(mode), .irq_lines_i(lines),
    .grp_sel_o(sel), .pending_o(pend)
  );

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // modules answer the code of the previous cycle; model compared every cycle
  always @(negedge clk) begin
    if (chk_en) begin
      check("R2 R3 code", 32'(sel), 32'(m_sel));
      check("R4 R5 R6 pending", pend, m_pend);
    end
    if (noise) lines = 8'hA5;
    else       lines = 8'(((src_a | src_b) >> (8 * seen_prev)) & 32'hFF);
    seen_prev = int'(sel);
    if (rst) begin
      m_sel = 0; m_act = int'(mode); m_pend = '0; m_vld = 0; m_prev = 0;
    end else begin
      if (m_vld && m_prev <= m_act) m_pend[8*m_prev +: 8] = lines;
      for (int g = 0; g < 4; g++) if (g > m_act) m_pend[8*g +: 8] = 8'h00;
      m_prev = m_sel; m_vld = 1;
      if (m_sel == m_act) begin m_sel = 0; m_act = int'(mode); end
      else m_sel = m_sel + 1;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    noise = 1'b1;
    cycles(3);
    chk_en = 1'b1;
    #2;
    check("R1 code in reset", 32'(sel), 0);
    check("R1 pending in reset", pend, 0);
    rst = 1'b0;                     // first free cycle still noisy
    cycles(1);
    noise = 1'b0;
    cycles(6);
    check("R8 noise discarded", pend, 0);

    src_a = 32'h0000_2000;          // level 13: group 1 bit 5
    cycles(8);
    check("R4 level 13 lands", pend, 32'h0000_2000);
    src_a = 32'h8000_0001; src_b = 32'h0001_0001;   // shared level 0
    cycles(8);
    check("R4 mixed groups", pend, 32'h8001_0001);
    src_a = '0; src_b = '0;
    cycles(7);
    check("R6 levels clear", pend, 0);

    mode = 2'd1; src_a = 32'hFFFF_FFFF;
    cycles(10);
    check("R5 two groups only", pend, 32'h0000_FFFF);

    mode = 2'd0;
    cycles(6);
    check("R3 single group code", 32'(sel), 0);
    check("R5 one group only", pend, 32'h0000_00FF);

    mode = 2'd3;
    cycles(10);
    check("R4 all groups", pend, 32'hFFFF_FFFF);
    while (sel != 2'd1) cycles(1);
    mode = 2'd0;                    // mid-scan change
    cycles(1);
    check("R7 scan continues", 32'(sel), 2);
    cycles(1);
    check("R7 last old group", 32'(sel), 3);
    cycles(1);
    check("R7 wrap", 32'(sel), 0);
    cycles(3);
    check("R7 new length", 32'(sel), 0);
    check("R5 shrink clears", pend, 32'h0000_00FF);

    mode = 2'd2;
    cycles(8);
    src_a = 32'h00C3_0000;
    cycles(8);
    check("R4 group 2 in three-group scan", pend, 32'h00C3_0000);
    rst = 1'b1;
    cycles(1);
    rst = 1'b0;
    #2;
    check("R1 reset mid-run", pend, 0);
    cycles(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule